// File: doc/BRIEF.md
# Predictive Deadtime Controller for a Synchronous Buck Stage

This block converts one PWM command into two gate enables for a synchronous buck power stage. `gate_main` drives the high-side main switch and `gate_rect` drives the low-side synchronous rectifier. When the command changes level, the gate that must stop is released one clock later. The gate that must start is held back for a programmed number of fast timing-clock cycles. That wait is the deadtime.

The two turn-on waits are kept in separate step registers, one for each transition direction. When a turn-on completes, the controller samples a digitised body-diode conduction flag for that transition. If conduction was seen, the deadtime was too long and the register is shortened by one step. If not, the register is lengthened by one step. The new value takes effect on the next switching cycle, so each loop ends up hovering at the edge of conduction.

The outputs stay low after reset, and again after the supply-good flag drops, until a fresh rising edge of the command arrives. Pulling the enable low also forces both gates off and freezes both step registers.

Top module: `pgd_deadtime_ctrl`

## Requirements
- R1: `gate_main` and `gate_rect` are never high in the same cycle. `gate_main` only turns on while the command is high, and `gate_rect` only while it is low.
- R2: Turn-off has a fixed delay. A high gate goes low on the first clock edge that samples the command at the opposite level.
- R3: A gate turns on exactly idx+1 clocks after the opposite gate went low. Here idx is the step register of that transition: main for the low-to-high command edge, rectifier for the high-to-low command edge.
- R4: At each completed turn-on, that transition's step register is updated once. It drops by one when the matching sense flag is high at that edge and rises by one when the flag is low. The new value first governs the next switching cycle.
- R5: The main register saturates at 0 and MAIN_MAX (default 14). The rectifier register saturates at 0 and RECT_MAX (default 15). Neither wraps.
- R6: After reset both gates are low and both step registers hold half of their maximum, rounded down (7 and 7 with the defaults).
- R7: After reset, both gates stay low until the command rises while enable and supply-good are high. A command held low does not turn on the rectifier. The sampled command level resets to high, so a command that is already high at reset does not count as a rising edge.
- R8: A low enable forces both gates low on the next clock and leaves both step registers unchanged. Once enable returns, the gates stay low until the next rising edge of the command.
- R9: The first main-switch turn-on after a restart (reset, disable or supply loss) uses the held main register and does not update it.
- R10: If the command reverses before a pending turn-on completes, that gate never turns on and its register is not updated. The opposite transition starts its own deadtime at once.
- R11: A low supply-good forces both gates low on the next clock and clears the start latch. The step registers are held. Restoring supply-good while the command is already high does not restart the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; one period is one deadtime step |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_cmd | input | 1 | PWM command; high requests the main switch |
| drv_en | input | 1 | Drive enable; low forces both gates off |
| supply_ok | input | 1 | Supply-good flag; low forces gates off and clears the start latch |
| cond_sense_main | input | 1 | Diode conduction flag for the rectifier-off to main-on transition |
| cond_sense_rect | input | 1 | Diode conduction flag for the main-off to rectifier-on transition |
| gate_main | output | 1 | High-side main switch enable |
| gate_rect | output | 1 | Low-side synchronous rectifier enable |

## Verification
The sense flags are driven by a plant model that reports conduction whenever the bench's own copy of the step register exceeds an ideal setting. Because the model depends on that copy, every measured deadtime checks both the one-step update and the one-cycle lag between a measurement and its use.

The bench uses four kinds of ideal setting. Mid-range ideals show the loops converging and then dithering within one step. An ideal below zero drives both registers to the lower limit, and an ideal far above range drives them to the upper limit; together these expose any wrap at either end. Ideals that change at random intervals, combined with random on-times, check that the two loops stay independent.

Directed patterns cover the remaining behaviour:
- a command that reverses mid-deadtime, to catch a wrongly counted update;
- toggling the command while disabled, to confirm the registers are frozen;
- returning the supply while the command is already high, to confirm the start latch is cleared.

// File: rtl/pgd_pkg.sv
`timescale 1ns/1ps
package pgd_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_DEAD_M = 3'd1,
    PH_MAIN   = 3'd2,
    PH_DEAD_R = 3'd3,
    PH_RECT   = 3'd4
  } phase_e;

  // One saturating step: shorten on conduction, lengthen otherwise.
  function automatic int unsigned step_next(int unsigned cur,
                                            int unsigned lim,
                                            logic        shorten);
    int unsigned r;
    if (shorten) r = (cur == 0) ? 0 : cur - 1;
    else         r = (cur >= lim) ? lim : cur + 1;
    return r;
  endfunction

  function automatic int unsigned mid_point(int unsigned lim);
    return lim / 2;
  endfunction

endpackage

// File: rtl/pgd_step_loop.sv
`timescale 1ns/1ps
module pgd_step_loop #(
  parameter int MAX_IDX = 14,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             sense,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] MID = IDX_W'(pgd_pkg::mid_point(MAX_IDX));

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_step;

  assign idx_step = IDX_W'(pgd_pkg::step_next(32'(idx_q), MAX_IDX, sense));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= MID;
    else if (upd) idx_q <= idx_step;
  end

  assign idx = idx_q;
endmodule

// File: rtl/pgd_phase_fsm.sv
`timescale 1ns/1ps
module pgd_phase_fsm #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_cmd,
  input  logic             drv_en,
  input  logic             supply_ok,
  input  logic [IDX_W-1:0] idx_main,
  input  logic [IDX_W-1:0] idx_rect,
  output logic             gate_main,
  output logic             gate_rect,
  output logic             upd_main,
  output logic             upd_rect
);
  import pgd_pkg::*;

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             skip_q, skip_d;
  logic             pwm_q;

  logic run, cmd_rise, fire_main, fire_rect;

  assign run       = drv_en & supply_ok;
  assign cmd_rise  = pwm_cmd & ~pwm_q;
  assign fire_main = run && (phase_q == PH_DEAD_M) && pwm_cmd  && (cnt_q == idx_main);
  assign fire_rect = run && (phase_q == PH_DEAD_R) && !pwm_cmd && (cnt_q == idx_rect);
  assign upd_main  = fire_main && !skip_q;
  assign upd_rect  = fire_rect && !skip_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    skip_d  = skip_q;
    if (!run) begin
      phase_d = PH_OFF;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_OFF: if (cmd_rise) begin
          phase_d = PH_DEAD_M; cnt_d = '0; skip_d = 1'b1;
        end
        PH_DEAD_M: begin
          if (!pwm_cmd) begin
            phase_d = PH_DEAD_R; cnt_d = '0; skip_d = 1'b0;
          end else if (fire_main) begin
            phase_d = PH_MAIN; skip_d = 1'b0;
          end else cnt_d = cnt_q + IDX_W'(1);
        end
        PH_MAIN: if (!pwm_cmd) begin
          phase_d = PH_DEAD_R; cnt_d = '0; skip_d = 1'b0;
        end
        PH_DEAD_R: begin
          if (pwm_cmd) begin
            phase_d = PH_DEAD_M; cnt_d = '0; skip_d = 1'b0;
          end else if (fire_rect) begin
            phase_d = PH_RECT;
          end else cnt_d = cnt_q + IDX_W'(1);
        end
        PH_RECT: if (pwm_cmd) begin
          phase_d = PH_DEAD_M; cnt_d = '0; skip_d = 1'b0;
        end
        default: phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      skip_q  <= 1'b0;
      pwm_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      skip_q  <= skip_d;
      pwm_q   <= pwm_cmd;
    end
  end

  assign gate_main = (phase_q == PH_MAIN);
  assign gate_rect = (phase_q == PH_RECT);
endmodule

// File: rtl/pgd_deadtime_ctrl.sv
`timescale 1ns/1ps
module pgd_deadtime_ctrl #(
  parameter int MAIN_MAX = 14,
  parameter int RECT_MAX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic drv_en,
  input  logic supply_ok,
  input  logic cond_sense_main,
  input  logic cond_sense_rect,
  output logic gate_main,
  output logic gate_rect
);
  localparam int TOP_MAX = (MAIN_MAX > RECT_MAX) ? MAIN_MAX : RECT_MAX;
  localparam int IDX_W   = $clog2(TOP_MAX + 1);

  logic [1:0]       upd_v;
  logic [1:0]       sense_v;
  logic [IDX_W-1:0] idx_v [2];
  logic [IDX_W-1:0] idx_main, idx_rect;

  assign sense_v  = {cond_sense_rect, cond_sense_main};
  assign idx_main = idx_v[0];
  assign idx_rect = idx_v[1];

  // Index 0: rectifier-off to main-on; index 1: main-off to rectifier-on.
  for (genvar g = 0; g < 2; g++) begin : g_loop
    localparam int LIM = (g == 0) ? MAIN_MAX : RECT_MAX;
    pgd_step_loop #(.MAX_IDX(LIM), .IDX_W(IDX_W)) u_loop (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd_v[g]),
      .sense (sense_v[g]),
      .idx   (idx_v[g])
    );
  end

  pgd_phase_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_cmd   (pwm_cmd),
    .drv_en    (drv_en),
    .supply_ok (supply_ok),
    .idx_main  (idx_main),
    .idx_rect  (idx_rect),
    .gate_main (gate_main),
    .gate_rect (gate_rect),
    .upd_main  (upd_v[0]),
    .upd_rect  (upd_v[1])
  );
endmodule

// File: rtl/pgd_checker.sv
`timescale 1ns/1ps
module pgd_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_cmd,
  input logic             drv_en,
  input logic             supply_ok,
  input logic             gate_main,
  input logic             gate_rect,
  input logic [IDX_W-1:0] idx_main,
  input logic [IDX_W-1:0] idx_rect
);
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_main && gate_rect));

  assert_main_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_main) |-> $past(pwm_cmd));

  assert_rect_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_rect) |-> !$past(pwm_cmd));

  assert_main_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_main && !pwm_cmd) |=> !gate_main);

  assert_rect_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rect && pwm_cmd) |=> !gate_rect);

  assert_break_make_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_main) |-> !$past(gate_rect));

  assert_main_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx_main} == {1'b0, $past(idx_main)}) ||
    ({1'b0, idx_main} == {1'b0, $past(idx_main)} + 1'b1) ||
    ({1'b0, idx_main} + 1'b1 == {1'b0, $past(idx_main)}));

  assert_rect_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx_rect} == {1'b0, $past(idx_rect)}) ||
    ({1'b0, idx_rect} == {1'b0, $past(idx_rect)} + 1'b1) ||
    ({1'b0, idx_rect} + 1'b1 == {1'b0, $past(idx_rect)}));

  assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> (!gate_main && !gate_rect));

  assert_disable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> ($stable(idx_main) && $stable(idx_rect)));

  assert_supply_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!gate_main && !gate_rect));
endmodule

bind pgd_deadtime_ctrl pgd_checker #(.IDX_W(IDX_W)) u_pgd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_cmd   (pwm_cmd),
  .drv_en    (drv_en),
  .supply_ok (supply_ok),
  .gate_main (gate_main),
  .gate_rect (gate_rect),
  .idx_main  (idx_main),
  .idx_rect  (idx_rect)
);

// File: tb/test_pgd_deadtime_ctrl.sv
`timescale 1ns/1ps
module test_pgd_deadtime_ctrl;
  localparam int MAIN_MAX = 14;
  localparam int RECT_MAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_cmd = 1'b0, drv_en = 1'b1, supply_ok = 1'b1;
  logic cond_sense_main = 1'b0, cond_sense_rect = 1'b0;
  logic gate_main, gate_rect;

  int n_chk = 0, n_err = 0, overlap = 0;
  int exp_m, exp_r, ideal_m, ideal_r, last_m, last_r;
  bit fresh;

  always #2 clk = ~clk;

  pgd_deadtime_ctrl #(.MAIN_MAX(MAIN_MAX), .RECT_MAX(RECT_MAX)) i_pgd_deadtime_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .drv_en(drv_en),
    .supply_ok(supply_ok), .cond_sense_main(cond_sense_main),
    .cond_sense_rect(cond_sense_rect), .gate_main(gate_main), .gate_rect(gate_rect)
  );

  always @(negedge clk) if (rst_n && gate_main && gate_rect) overlap++;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Restated loop rule: conduction shortens, silence lengthens, clamp at limits.
  function automatic int model_step(int cur, int lim, bit cond);
    int v = cond ? cur - 1 : cur + 1;
    if (v < 0) v = 0;
    if (v > lim) v = lim;
    return v;
  endfunction

  task automatic turn_main(int hold);
    bit s;
    int n;
    s = (exp_m > ideal_m);
    cond_sense_main = s;
    pwm_cmd = 1'b1;
    @(negedge clk);
    chk(!gate_rect && !gate_main, "R2 rect off after one clock", {gate_rect, gate_main}, 0);
    n = 0;
    while (!gate_main && n < 40) begin @(negedge clk); n++; end
    last_m = n;
    chk(n == exp_m + 1, "R3/R4 main deadtime", n, exp_m + 1);
    if (!fresh) exp_m = model_step(exp_m, MAIN_MAX, s);
    fresh = 1'b0;
    repeat (hold) @(negedge clk);
  endtask

  task automatic turn_rect(int hold);
    bit s;
    int n;
    s = (exp_r > ideal_r);
    cond_sense_rect = s;
    pwm_cmd = 1'b0;
    @(negedge clk);
    chk(!gate_rect && !gate_main, "R2 main off after one clock", {gate_rect, gate_main}, 0);
    n = 0;
    while (!gate_rect && n < 40) begin @(negedge clk); n++; end
    last_r = n;
    chk(n == exp_r + 1, "R3/R4 rect deadtime", n, exp_r + 1);
    exp_r = model_step(exp_r, RECT_MAX, s);
    repeat (hold) @(negedge clk);
  endtask

  task automatic run_cycles(int k);
    for (int i = 0; i < k; i++) begin
      turn_main($urandom_range(0, 4));
      turn_rect($urandom_range(0, 4));
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20031));
    exp_m = MAIN_MAX / 2; exp_r = RECT_MAX / 2;
    ideal_m = 3; ideal_r = 11;
    repeat (4) @(negedge clk);
    chk(!gate_main && !gate_rect, "R6 reset outputs low", {gate_main, gate_rect}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!gate_main && !gate_rect, "R7 latch holds outputs low", {gate_main, gate_rect}, 0);

    // R6 / R9: midpoint start, first main turn-on does not update
    fresh = 1'b1;
    turn_main(2);
    chk(last_m == 8, "R6 main midpoint", last_m, 8);
    turn_rect(2);
    chk(last_r == 8, "R6 rect midpoint", last_r, 8);

    // R4 convergence
    run_cycles(25);
    chk(last_m - 1 >= ideal_m && last_m - 1 <= ideal_m + 1, "R4 main converged", last_m - 1, ideal_m);
    chk(last_r - 1 >= ideal_r && last_r - 1 <= ideal_r + 1, "R4 rect converged", last_r - 1, ideal_r);

    // R5 saturation low then high
    ideal_m = -5; ideal_r = -5;
    run_cycles(20);
    chk(last_m == 1, "R5 main floor", last_m, 1);
    chk(last_r == 1, "R5 rect floor", last_r, 1);
    ideal_m = 100; ideal_r = 100;
    run_cycles(22);
    chk(last_m == MAIN_MAX + 1, "R5 main ceiling", last_m, MAIN_MAX + 1);
    chk(last_r == RECT_MAX + 1, "R5 rect ceiling", last_r, RECT_MAX + 1);

    // R10 aborted main turn-on: sense high would shorten if counted
    ideal_m = 5;
    cond_sense_main = 1'b1;
    pwm_cmd = 1'b1;
    repeat (3) @(negedge clk);
    chk(!gate_main, "R10 aborted main stays off", gate_main, 0);
    turn_rect(2);
    turn_main(2);
    chk(last_m == MAIN_MAX + 1, "R10 main register untouched", last_m, MAIN_MAX + 1);

    // R8 disable while main on
    drv_en = 1'b0;
    @(negedge clk);
    chk(!gate_main && !gate_rect, "R8 disable forces low", {gate_main, gate_rect}, 0);
    for (int i = 0; i < 6; i++) begin
      pwm_cmd = ~pwm_cmd;
      cond_sense_main = $urandom_range(0, 1);
      cond_sense_rect = $urandom_range(0, 1);
      repeat (3) @(negedge clk);
      chk(!gate_main && !gate_rect, "R8 outputs low while disabled", {gate_main, gate_rect}, 0);
    end
    pwm_cmd = 1'b0;
    @(negedge clk);
    drv_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!gate_main && !gate_rect, "R8 restart waits for rising edge", {gate_main, gate_rect}, 0);
    fresh = 1'b1;
    turn_main(1);
    chk(last_m == exp_m + 1, "R8/R9 main held across disable", last_m, exp_m + 1);
    turn_rect(1);
    turn_main(1);
    turn_rect(1);

    // R11 supply loss while rectifier on
    supply_ok = 1'b0;
    @(negedge clk);
    chk(!gate_main && !gate_rect, "R11 supply loss forces low", {gate_main, gate_rect}, 0);
    pwm_cmd = 1'b1;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    repeat (5) @(negedge clk);
    chk(!gate_main && !gate_rect, "R11 latch cleared, high command ignored", {gate_main, gate_rect}, 0);
    pwm_cmd = 1'b0;
    repeat (3) @(negedge clk);
    chk(!gate_rect, "R7 low command does not start rectifier", gate_rect, 0);
    fresh = 1'b1;
    turn_main(1);
    turn_rect(1);

    // Random ideals, both loops independent
    for (int blk = 0; blk < 4; blk++) begin
      ideal_m = $urandom_range(0, MAIN_MAX);
      ideal_r = $urandom_range(0, RECT_MAX);
      run_cycles(18);
      chk(last_r - 1 >= ideal_r - 1 && last_r - 1 <= ideal_r + 1, "R4 rect tracks random ideal", last_r - 1, ideal_r);
    end

    chk(overlap == 0, "R1 no overlap seen", overlap, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule